// File: doc/BRIEF.md
# Oldest-First Multi-Issue Selector

This block picks, every cycle, which entries of an eight-slot instruction window are sent to the execution units. Each window entry supplies a valid bit, a ready bit and a two-bit unit class. The window is kept in physical age order, so entry 0 is the oldest and entry 7 the youngest. The selector walks the entries from oldest to youngest. It grants an eligible entry when two things still hold: an issue slot is free, and a unit of that entry's class is free. Once a class is used up, later entries of that class are passed over. Younger entries of other classes can still win the remaining slots.

The result is registered before it leaves the block. The stage that follows sees a per-entry grant vector and three issue slots. The slots are listed oldest first, and each one names the granted entry and the functional unit it is steered to. Operand wakeup, renaming and retirement belong to other blocks; readiness arrives here as an input bit.

Top module: `oldest_issue_sel`

## Requirements
- R1: While rst_n is low, every output is zero: grant vector, slot valid bits, slot indices and slot units.
- R2: An entry whose valid or ready bit is 0 is never granted.
- R3: No more than three entries are granted in one cycle.
- R4: In one cycle, at most two entries of class ALU (code 0) are granted, at most one of class MEM (code 1), and at most one of class BR (code 2).
- R5: Entry 0 is the oldest. The grant vector equals a greedy scan from entry 0 upward. That scan grants an eligible entry exactly when fewer than three entries are already granted and its class limit is not yet reached by older grants.
- R6: An eligible entry whose class is exhausted by older grants is skipped. Younger eligible entries of other classes are still granted while slots remain.
- R7: Each granted entry is steered to a unit code. The oldest ALU grant gets unit 0 and the second gets unit 1; MEM goes to unit 2 and BR to unit 3. No two valid slots carry the same unit.
- R8: Slot s is valid exactly when at least s+1 entries are granted. Its 3-bit index is the (s+1)-th oldest granted entry. Invalid slots show index 0 and unit 0.
- R9: Class code 3 is reserved, and an entry carrying it is never granted.
- R10: Outputs change only on a rising clock edge and reflect the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_valid | input | 8 | Entry holds an instruction, bit i for entry i |
| ent_ready | input | 8 | Entry operands are ready |
| ent_class | input | 16 | Two-bit unit class per entry, entry i at bits 2i+1:2i |
| grant_q | output | 8 | Registered per-entry grant |
| slot_vld_q | output | 3 | Registered issue-slot valid bits |
| slot_idx_q | output | 9 | Entry index per slot, slot s at bits 3s+2:3s |
| slot_unit_q | output | 6 | Unit code per slot, slot s at bits 2s+1:2s |

## Verification
Two limits can cut the same scan: the issue-width cap and a class cap. The interesting cycles are those where a class runs out while slots remain, and then the width cap stops a younger entry of another class. The bench builds such windows on purpose. One example is two MEM entries followed by ALU, BR and ALU. The outcome is judged against an independent greedy model in the bench, on both the grant vector and the slot-by-slot unit steering. Random valid, ready and class patterns then mix the two limits in many other orders.

// File: rtl/sel_pkg.sv
package sel_pkg;
  localparam int CLS_W = 2;
  typedef enum logic [CLS_W-1:0] {
    CLS_ALU = 2'd0,
    CLS_MEM = 2'd1,
    CLS_BR  = 2'd2,
    CLS_RSV = 2'd3
  } cls_e;
endpackage

// File: rtl/sel_age_scan.sv
// Greedy age-ordered scan: entry 0 is oldest; running counters ripple down.
module sel_age_scan
  import sel_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int ISSUE_W = 3,
  parameter int N_ALU   = 2,
  parameter int N_MEM   = 1,
  parameter int N_BR    = 1,
  localparam int N_UNIT = N_ALU + N_MEM + N_BR,
  localparam int UNIT_W = (N_UNIT > 1) ? $clog2(N_UNIT) : 1,
  localparam int RANK_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1
) (
  input  logic [NUM_ENT-1:0]        elig_i,
  input  logic [NUM_ENT*CLS_W-1:0]  cls_i,
  output logic [NUM_ENT-1:0]        grant_o,
  output logic [NUM_ENT*UNIT_W-1:0] unit_o,
  output logic [NUM_ENT*RANK_W-1:0] rank_o
);
  localparam int CW = $clog2(NUM_ENT + N_UNIT + 1);
  localparam logic [CW-1:0] L_SLOT  = CW'(ISSUE_W);
  localparam logic [CW-1:0] L_ALU   = CW'(N_ALU);
  localparam logic [CW-1:0] L_MEM   = CW'(N_MEM);
  localparam logic [CW-1:0] L_BR    = CW'(N_BR);
  localparam logic [CW-1:0] B_MEM   = CW'(N_ALU);
  localparam logic [CW-1:0] B_BR    = CW'(N_ALU + N_MEM);

  logic [CW-1:0] n_slot [NUM_ENT+1];
  logic [CW-1:0] n_alu  [NUM_ENT+1];
  logic [CW-1:0] n_mem  [NUM_ENT+1];
  logic [CW-1:0] n_br   [NUM_ENT+1];

  assign n_slot[0] = '0;
  assign n_alu[0]  = '0;
  assign n_mem[0]  = '0;
  assign n_br[0]   = '0;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic [CLS_W-1:0] cls;
    logic is_alu, is_mem, is_br, cls_room, gnt;
    logic [CW-1:0] ufull;

    assign cls    = cls_i[i*CLS_W +: CLS_W];
    assign is_alu = (cls == CLS_ALU);
    assign is_mem = (cls == CLS_MEM);
    assign is_br  = (cls == CLS_BR);

    always_comb begin
      cls_room = 1'b0;
      ufull    = '0;
      if (is_alu) begin
        cls_room = (n_alu[i] < L_ALU);
        ufull    = n_alu[i];
      end else if (is_mem) begin
        cls_room = (n_mem[i] < L_MEM);
        ufull    = B_MEM + n_mem[i];
      end else if (is_br) begin
        cls_room = (n_br[i] < L_BR);
        ufull    = B_BR + n_br[i];
      end
    end

    assign gnt = elig_i[i] & cls_room & (n_slot[i] < L_SLOT);

    assign n_slot[i+1] = n_slot[i] + {{(CW-1){1'b0}}, gnt};
    assign n_alu[i+1]  = n_alu[i]  + {{(CW-1){1'b0}}, gnt & is_alu};
    assign n_mem[i+1]  = n_mem[i]  + {{(CW-1){1'b0}}, gnt & is_mem};
    assign n_br[i+1]   = n_br[i]   + {{(CW-1){1'b0}}, gnt & is_br};

    assign grant_o[i]                  = gnt;
    assign unit_o[i*UNIT_W +: UNIT_W]  = ufull[UNIT_W-1:0];
    assign rank_o[i*RANK_W +: RANK_W]  = n_slot[i][RANK_W-1:0];
  end
endmodule

// File: rtl/sel_slot_pack.sv
// Gathers granted entries into issue slots, oldest grant in slot 0.
module sel_slot_pack #(
  parameter int NUM_ENT = 8,
  parameter int ISSUE_W = 3,
  parameter int UNIT_W  = 2,
  parameter int RANK_W  = 2,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0]        grant_i,
  input  logic [NUM_ENT*UNIT_W-1:0] unit_i,
  input  logic [NUM_ENT*RANK_W-1:0] rank_i,
  output logic [ISSUE_W-1:0]        slot_vld_o,
  output logic [ISSUE_W*IDX_W-1:0]  slot_idx_o,
  output logic [ISSUE_W*UNIT_W-1:0] slot_unit_o
);
  for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
    logic             vld;
    logic [IDX_W-1:0]  idx;
    logic [UNIT_W-1:0] unit;

    always_comb begin
      vld  = 1'b0;
      idx  = '0;
      unit = '0;
      for (int i = 0; i < NUM_ENT; i++) begin
        if (grant_i[i] && (rank_i[i*RANK_W +: RANK_W] == RANK_W'(s))) begin
          vld  = 1'b1;
          idx  = idx  | IDX_W'(i);
          unit = unit | unit_i[i*UNIT_W +: UNIT_W];
        end
      end
    end

    assign slot_vld_o[s]                  = vld;
    assign slot_idx_o[s*IDX_W +: IDX_W]   = idx;
    assign slot_unit_o[s*UNIT_W +: UNIT_W] = unit;
  end
endmodule

// File: rtl/oldest_issue_sel.sv
module oldest_issue_sel
  import sel_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int ISSUE_W = 3,
  parameter int N_ALU   = 2,
  parameter int N_MEM   = 1,
  parameter int N_BR    = 1,
  localparam int N_UNIT = N_ALU + N_MEM + N_BR,
  localparam int UNIT_W = (N_UNIT > 1) ? $clog2(N_UNIT) : 1,
  localparam int RANK_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_ENT-1:0]        ent_valid,
  input  logic [NUM_ENT-1:0]        ent_ready,
  input  logic [NUM_ENT*CLS_W-1:0]  ent_class,
  output logic [NUM_ENT-1:0]        grant_q,
  output logic [ISSUE_W-1:0]        slot_vld_q,
  output logic [ISSUE_W*IDX_W-1:0]  slot_idx_q,
  output logic [ISSUE_W*UNIT_W-1:0] slot_unit_q
);
  logic [NUM_ENT-1:0]        elig;
  logic [NUM_ENT-1:0]        grant_d;
  logic [NUM_ENT*UNIT_W-1:0] unit_d;
  logic [NUM_ENT*RANK_W-1:0] rank_d;
  logic [ISSUE_W-1:0]        slot_vld_d;
  logic [ISSUE_W*IDX_W-1:0]  slot_idx_d;
  logic [ISSUE_W*UNIT_W-1:0] slot_unit_d;

  assign elig = ent_valid & ent_ready;

  sel_age_scan #(
    .NUM_ENT(NUM_ENT), .ISSUE_W(ISSUE_W),
    .N_ALU(N_ALU), .N_MEM(N_MEM), .N_BR(N_BR)
  ) u_scan (
    .elig_i (elig),
    .cls_i  (ent_class),
    .grant_o(grant_d),
    .unit_o (unit_d),
    .rank_o (rank_d)
  );

  sel_slot_pack #(
    .NUM_ENT(NUM_ENT), .ISSUE_W(ISSUE_W),
    .UNIT_W(UNIT_W), .RANK_W(RANK_W)
  ) u_pack (
    .grant_i    (grant_d),
    .unit_i     (unit_d),
    .rank_i     (rank_d),
    .slot_vld_o (slot_vld_d),
    .slot_idx_o (slot_idx_d),
    .slot_unit_o(slot_unit_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q     <= '0;
      slot_vld_q  <= '0;
      slot_idx_q  <= '0;
      slot_unit_q <= '0;
    end else begin
      grant_q     <= grant_d;
      slot_vld_q  <= slot_vld_d;
      slot_idx_q  <= slot_idx_d;
      slot_unit_q <= slot_unit_d;
    end
  end
endmodule

// File: rtl/oldest_issue_sel_chk.sv
module oldest_issue_sel_chk
  import sel_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int ISSUE_W = 3,
  parameter int N_ALU   = 2,
  parameter int N_MEM   = 1,
  parameter int N_BR    = 1,
  localparam int N_UNIT = N_ALU + N_MEM + N_BR,
  localparam int UNIT_W = (N_UNIT > 1) ? $clog2(N_UNIT) : 1,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_ENT-1:0]        ent_valid,
  input logic [NUM_ENT-1:0]        ent_ready,
  input logic [NUM_ENT*CLS_W-1:0]  ent_class,
  input logic [NUM_ENT-1:0]        grant_q,
  input logic [ISSUE_W-1:0]        slot_vld_q,
  input logic [ISSUE_W*IDX_W-1:0]  slot_idx_q,
  input logic [ISSUE_W*UNIT_W-1:0] slot_unit_q
);
  logic [NUM_ENT-1:0]       prev_elig;
  logic [NUM_ENT*CLS_W-1:0] prev_cls;
  int n_alu, n_mem, n_br;
  logic [NUM_ENT-1:0] rsv_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_elig <= '0;
      prev_cls  <= '0;
    end else begin
      prev_elig <= ent_valid & ent_ready;
      prev_cls  <= ent_class;
    end
  end

  always_comb begin
    n_alu = 0; n_mem = 0; n_br = 0; rsv_hit = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (grant_q[i]) begin
        case (prev_cls[i*CLS_W +: CLS_W])
          CLS_ALU: n_alu++;
          CLS_MEM: n_mem++;
          CLS_BR:  n_br++;
          default: rsv_hit[i] = 1'b1;
        endcase
      end
    end
  end

  p_elig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q & ~prev_elig) == '0);
  p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_q) <= ISSUE_W);
  p_alu_cap_r4: assert property (@(posedge clk) disable iff (!rst_n) n_alu <= N_ALU);
  p_mem_cap_r4: assert property (@(posedge clk) disable iff (!rst_n) n_mem <= N_MEM);
  p_br_cap_r4:  assert property (@(posedge clk) disable iff (!rst_n) n_br <= N_BR);
  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n) rsv_hit == '0);
  p_slot_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_vld_q) == $countones(grant_q));

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    logic [ISSUE_W-1:0] hit;
    for (genvar s = 0; s < ISSUE_W; s++) begin : g_s
      assign hit[s] = slot_vld_q[s] && (slot_unit_q[s*UNIT_W +: UNIT_W] == UNIT_W'(u));
    end
    p_unit_unique_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
  end

  for (genvar s = 0; s < ISSUE_W; s++) begin : g_sl
    logic [IDX_W-1:0] sidx;
    assign sidx = slot_idx_q[s*IDX_W +: IDX_W];
    p_slot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld_q[s] |-> grant_q[sidx]);
    p_unit_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
      slot_vld_q[s] |-> ((slot_unit_q[s*UNIT_W +: UNIT_W] < UNIT_W'(N_ALU)) ==
                         (prev_cls[sidx*CLS_W +: CLS_W] == CLS_ALU)));
    if (s > 0) begin : g_ord
      p_slot_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld_q[s] |-> (slot_vld_q[s-1] &&
                           (slot_idx_q[(s-1)*IDX_W +: IDX_W] < sidx)));
    end
  end
endmodule

bind oldest_issue_sel oldest_issue_sel_chk #(
  .NUM_ENT(NUM_ENT), .ISSUE_W(ISSUE_W),
  .N_ALU(N_ALU), .N_MEM(N_MEM), .N_BR(N_BR)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_class(ent_class),
  .grant_q(grant_q), .slot_vld_q(slot_vld_q),
  .slot_idx_q(slot_idx_q), .slot_unit_q(slot_unit_q)
);

// File: tb/sim_oldest_issue_sel.sv
module sim_oldest_issue_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ent_valid, ent_ready;
  logic [15:0] ent_class;
  logic [7:0]  grant_q;
  logic [2:0]  slot_vld_q;
  logic [8:0]  slot_idx_q;
  logic [5:0]  slot_unit_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_g;
  logic [2:0] exp_v;
  logic [2:0] exp_i [3];
  logic [1:0] exp_u [3];

  always #2.5 clk = ~clk;

  oldest_issue_sel u0 (
    .clk(clk), .rst_n(rst_n),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_class(ent_class),
    .grant_q(grant_q), .slot_vld_q(slot_vld_q),
    .slot_idx_q(slot_idx_q), .slot_unit_q(slot_unit_q)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent greedy reference: ALU=0 MEM=1 BR=2, units ALU0/1=0/1 MEM=2 BR=3.
  task automatic model(input logic [7:0] v, input logic [7:0] r, input logic [15:0] c);
    int na = 0, nm = 0, nb = 0, ns = 0;
    exp_g = '0; exp_v = '0;
    for (int s = 0; s < 3; s++) begin exp_i[s] = '0; exp_u[s] = '0; end
    for (int i = 0; i < 8; i++) begin
      logic [1:0] k;
      logic [1:0] u;
      bit ok;
      k = c[2*i +: 2];
      ok = 1'b0; u = 2'd0;
      if (v[i] && r[i] && ns < 3) begin
        if (k == 2'd0 && na < 2) begin ok = 1'b1; u = 2'(na); na++; end
        else if (k == 2'd1 && nm < 1) begin ok = 1'b1; u = 2'd2; nm++; end
        else if (k == 2'd2 && nb < 1) begin ok = 1'b1; u = 2'd3; nb++; end
      end
      if (ok) begin
        exp_g[i] = 1'b1; exp_v[ns] = 1'b1; exp_i[ns] = 3'(i); exp_u[ns] = u; ns++;
      end
    end
  endtask

  task automatic apply(input string req, input logic [7:0] v, input logic [7:0] r, input logic [15:0] c);
    @(negedge clk);
    ent_valid = v; ent_ready = r; ent_class = c;
    model(v, r, c);
    @(posedge clk); #1;
    chk(req, "grant", 16'(grant_q), 16'(exp_g));
    for (int s = 0; s < 3; s++)
      chk(req, $sformatf("slot%0d vld/idx/unit", s),
          {10'd0, slot_vld_q[s], slot_idx_q[3*s +: 3], slot_unit_q[2*s +: 2]},
          {10'd0, exp_v[s], exp_i[s], exp_u[s]});
  endtask

  function automatic logic [15:0] pk(input logic [1:0] c0, c1, c2, c3, c4, c5, c6, c7);
    return {c7, c6, c5, c4, c3, c2, c1, c0};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; ent_valid = '1; ent_ready = '1; ent_class = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset outputs", {1'b0, grant_q, slot_vld_q, slot_unit_q[3:0]}, 16'd0);
    chk("R1", "reset idx", 16'(slot_idx_q), 16'd0);
    @(negedge clk); rst_n = 1'b1; ent_valid = '0;
  endtask

  task automatic t_two_limits();
    // MEM,MEM,ALU,BR,ALU: second MEM skipped, width stops last ALU
    apply("R6", 8'h1F, 8'hFF, pk(1, 1, 0, 2, 0, 0, 0, 0));
    chk("R6", "skip mem grant", 16'(grant_q), 16'h000D);
    chk("R7", "unit order", 16'(slot_unit_q), 16'({2'd3, 2'd0, 2'd2}));
    apply("R3", 8'h1F, 8'hFF, pk(1, 0, 1, 2, 0, 0, 0, 0));
    chk("R3", "mixed grant", 16'(grant_q), 16'h000B);
  endtask

  task automatic t_alu_flood();
    apply("R4", 8'hFF, 8'hFF, pk(0, 0, 0, 0, 0, 0, 0, 0));
    chk("R4", "alu cap", 16'(grant_q), 16'h0003);
    chk("R7", "alu units", 16'(slot_unit_q[3:0]), 16'({2'd1, 2'd0}));
    apply("R6", 8'hFF, 8'hFF, pk(0, 0, 0, 0, 0, 0, 0, 1));
    chk("R6", "young mem", 16'(grant_q), 16'h0083);
  endtask

  task automatic t_not_eligible();
    apply("R2", 8'hF0, 8'hFF, pk(0, 0, 0, 0, 0, 2, 1, 0));
    chk("R2", "invalid skipped", 16'(grant_q), 16'h0070);
    apply("R2", 8'hFF, 8'h0F, pk(2, 2, 2, 2, 0, 0, 0, 0));
    chk("R2", "not ready skipped", 16'(grant_q), 16'h0001);
    apply("R8", 8'h00, 8'hFF, pk(0, 0, 0, 0, 0, 0, 0, 0));
    chk("R8", "empty slots", {7'd0, slot_vld_q, slot_idx_q[5:0]}, 16'd0);
  endtask

  task automatic t_reserved();
    apply("R9", 8'hFF, 8'hFF, pk(3, 3, 3, 2, 3, 3, 3, 3));
    chk("R9", "reserved never granted", 16'(grant_q), 16'h0008);
  endtask

  task automatic t_registered();
    apply("R10", 8'h01, 8'h01, pk(1, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    ent_valid = 8'h02; ent_ready = 8'h02; ent_class = pk(0, 2, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R10", "held before edge", 16'(grant_q), 16'h0001);
    @(posedge clk); #1;
    chk("R10", "updated after edge", {8'(grant_q), 2'd0, slot_unit_q}, {8'h02, 2'd0, 6'd3});
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++)
      apply("R5", 8'($urandom), 8'($urandom | $urandom), 16'($urandom));
  endtask

  initial begin
    void'($urandom(32'd7));
    t_reset();
    t_two_limits();
    t_alu_flood();
    t_not_eligible();
    t_reserved();
    t_registered();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule